// File: doc/BRIEF.md
# Polyphase DFT channel expander

This block takes one stream of real signed samples and splits it into Q sub-channels. Each sub-channel runs at 1/Q of the input rate and carries one frequency slice of the input. Incoming samples are dealt round-robin to Q branches. Each branch keeps a short delay line and applies one polyphase slice of a common lowpass prototype, at the decimated rate only.

Once a column of Q samples is complete, a Q-point forward DFT is taken across the Q branch results. All Q complex bins leave the block together on a parallel lane bus, marked by one valid strobe. Lane k is the input shifted down in frequency by k/Q of the sample rate, lowpass filtered and decimated by Q. A single short prototype and one transform therefore stand in for Q separate mix, filter and decimate chains. All lanes stay cycle-aligned.

The prototype is a triangular window. It is computed at elaboration from the parameters. The twiddle factors are computed the same way. The channel count need not be a power of two.

Top module: `polydft_expander`

## Requirements
- R1: `in_ready` is low while `rst` is high and high otherwise. A sample is accepted on a rising edge where `in_valid` and `in_ready` are both high. The n-th accepted sample since reset (counting from 0) goes to branch n mod Q. Every Q-th accepted sample closes a column.
- R2: `out_valid` is a one-cycle pulse. It is high in the cycle that follows the second rising edge after the edge that accepted the last sample of a column. There is exactly one pulse per column, and all Q lanes are presented in that same cycle.
- R3: Lane k sits at bits k·OW +: OW of `out_re` and of `out_im`. Each lane is signed two's complement in units of one input LSB. Lane k equals, within ±2 LSB, the real and imaginary part of Σ_i h[i]·x[t−i]·e^(−j2πk(t−i)/Q). Here t is the index of the column's last sample, and x is zero before the first sample accepted after reset.
- R4: The prototype tap i is h[i] = min(i+1, L−i)·COEF_UNIT / 2^(CW−1), with L = Q·TAPS. A lone impulse therefore reproduces the prototype taps, spread across the lanes and columns that follow it.
- R5: A cycle with `in_valid` low accepts nothing. It does not advance commutation, does not change filter state and does not raise `out_valid`. A stream with idle gaps gives the same lane values as the same stream without gaps.
- R6: A synchronous reset clears every delay line, every branch register and any pending output, and restarts commutation at branch 0. `out_valid` is low during reset and in the cycle after it.
- R7: The default configuration is Q = 5, which is not a power of two, and it follows R1 to R4 unchanged. Energy at input frequency 2/Q of the sample rate appears on lane 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | One-cycle strobe: all lanes hold a new column |
| out_re | output | Q·OW | Real parts, lane k at bits k·OW +: OW |
| out_im | output | Q·OW | Imaginary parts, lane k at bits k·OW +: OW |

## Verification
Two things coincide under back-to-back streaming. The edge that loads the branch registers from a finished column is the same edge that shifts the next column's first sample into branch 0's delay line. Only the pre-edge contents belong to the old column. Continuous valid input provokes this on every column. The lanes are judged against a full-rate model that mixes each sample by a complex exponential, filters it with the whole prototype and keeps every Q-th result. A mid-column reset and randomly gapped input check that column boundaries and filter history stay correct around both events.

// File: rtl/polydft_pkg.sv
package polydft_pkg;

  // triangular prototype tap, integer coefficient units
  function automatic int proto_tap(input int idx, input int len, input int unit);
    int up;
    int dn;
    up = idx + 1;
    dn = len - idx;
    return ((up < dn) ? up : dn) * unit;
  endfunction

  // forward DFT twiddle e^(-j2*pi*idx/q), scaled by 2^(tw-2), rounded
  function automatic int twiddle(input int kn, input int q, input bit imag, input int tw);
    real ang;
    real v;
    real s;
    ang = 6.283185307179586 * real'(kn % q) / real'(q);
    v   = imag ? -$sin(ang) : $cos(ang);
    s   = v * real'(1 << (tw - 2));
    return (s >= 0.0) ? $rtoi(s + 0.5) : -$rtoi(-s + 0.5);
  endfunction

endpackage

// File: rtl/polydft_commutator.sv
module polydft_commutator #(
  parameter int Q  = 5,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          accept,
  output logic [SW-1:0] sel,
  output logic          col_done
);

  localparam logic [SW-1:0] LAST = SW'(Q - 1);

  assign accept = in_valid & ~rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel      <= '0;
      col_done <= 1'b0;
    end else begin
      col_done <= accept && (sel == LAST);
      if (accept) sel <= (sel == LAST) ? '0 : sel + 1'b1;
    end
  end

endmodule

// File: rtl/polydft_branch.sv
module polydft_branch #(
  parameter int Q         = 5,
  parameter int TAPS      = 4,
  parameter int DW        = 12,
  parameter int CW        = 16,
  parameter int AW        = 31,
  parameter int BR        = 0,
  parameter int COEF_UNIT = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic signed [DW-1:0] din,
  input  logic                 cap,
  output logic signed [AW-1:0] y
);

  localparam int L = Q * TAPS;

  logic signed [DW-1:0] dl   [TAPS];
  logic signed [CW-1:0] coef [TAPS];
  logic signed [AW-1:0] mac;

  // branch BR holds the samples at column offset BR, so it takes phase Q-1-BR
  for (genvar m = 0; m < TAPS; m++) begin : g_coef
    assign coef[m] = CW'(polydft_pkg::proto_tap(Q * m + Q - 1 - BR, L, COEF_UNIT));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int m = 0; m < TAPS; m++) dl[m] <= '0;
    end else if (load) begin
      dl[0] <= din;
      for (int m = 1; m < TAPS; m++) dl[m] <= dl[m-1];
    end
  end

  always_comb begin
    mac = '0;
    for (int m = 0; m < TAPS; m++) mac = mac + (AW'(dl[m]) * AW'(coef[m]));
  end

  always_ff @(posedge clk) begin
    if (rst)      y <= '0;
    else if (cap) y <= mac;
  end

endmodule

// File: rtl/polydft_dft.sv
module polydft_dft #(
  parameter int Q  = 5,
  parameter int AW = 31,
  parameter int TW = 16,
  parameter int OW = 16,
  parameter int SH = 29
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go,
  input  logic signed [AW-1:0] y [Q],
  output logic                 done,
  output logic [Q*OW-1:0]      lanes_re,
  output logic [Q*OW-1:0]      lanes_im
);

  localparam int DAW = AW + TW + $clog2(Q) + 1;
  localparam logic signed [DAW-1:0] HALF = DAW'(1) <<< (SH - 1);

  logic signed [TW-1:0] tw_re [Q][Q];
  logic signed [TW-1:0] tw_im [Q][Q];

  for (genvar k = 0; k < Q; k++) begin : g_lane
    for (genvar n = 0; n < Q; n++) begin : g_tw
      localparam int TRE = polydft_pkg::twiddle(k * n, Q, 1'b0, TW);
      localparam int TIM = polydft_pkg::twiddle(k * n, Q, 1'b1, TW);
      assign tw_re[k][n] = TW'(TRE);
      assign tw_im[k][n] = TW'(TIM);
    end

    logic signed [DAW-1:0] acc_re, acc_im, sh_re, sh_im;
    logic signed [OW-1:0]  q_re, q_im;

    always_comb begin
      acc_re = '0;
      acc_im = '0;
      for (int n = 0; n < Q; n++) begin
        acc_re = acc_re + DAW'(y[n]) * DAW'(tw_re[k][n]);
        acc_im = acc_im + DAW'(y[n]) * DAW'(tw_im[k][n]);
      end
      sh_re = (acc_re + HALF) >>> SH;
      sh_im = (acc_im + HALF) >>> SH;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        q_re <= '0;
        q_im <= '0;
      end else if (go) begin
        q_re <= OW'(sh_re);
        q_im <= OW'(sh_im);
      end
    end

    assign lanes_re[k*OW +: OW] = q_re;
    assign lanes_im[k*OW +: OW] = q_im;
  end

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= go;
  end

endmodule

// File: rtl/polydft_expander.sv
module polydft_expander #(
  parameter int Q         = 5,
  parameter int TAPS      = 4,
  parameter int DW        = 12,
  parameter int CW        = 16,
  parameter int TW        = 16,
  parameter int OW        = 16,
  parameter int COEF_UNIT = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic [Q*OW-1:0]      out_re,
  output logic [Q*OW-1:0]      out_im
);

  localparam int SW = (Q > 1) ? $clog2(Q) : 1;
  localparam int AW = DW + CW + $clog2(TAPS) + 1;
  localparam int SH = (CW - 1) + (TW - 2);

  logic                 accept;
  logic [SW-1:0]        sel;
  logic                 col_done;
  logic                 y_vld;
  logic signed [AW-1:0] br_y [Q];

  assign in_ready = ~rst;

  polydft_commutator #(.Q(Q), .SW(SW)) u_comm (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .accept(accept), .sel(sel), .col_done(col_done)
  );

  for (genvar n = 0; n < Q; n++) begin : g_br
    polydft_branch #(
      .Q(Q), .TAPS(TAPS), .DW(DW), .CW(CW), .AW(AW), .BR(n), .COEF_UNIT(COEF_UNIT)
    ) u_br (
      .clk(clk), .rst(rst),
      .load(accept && (sel == SW'(n))),
      .din(in_data), .cap(col_done), .y(br_y[n])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) y_vld <= 1'b0;
    else     y_vld <= col_done;
  end

  polydft_dft #(.Q(Q), .AW(AW), .TW(TW), .OW(OW), .SH(SH)) u_dft (
    .clk(clk), .rst(rst), .go(y_vld), .y(br_y),
    .done(out_valid), .lanes_re(out_re), .lanes_im(out_im)
  );

endmodule

// File: rtl/polydft_expander_chk.sv
module polydft_expander_chk #(
  parameter int Q  = 5,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          accept,
  input logic [SW-1:0] sel,
  input logic          col_done,
  input logic          y_vld,
  input logic          out_valid
);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R1
  sel_range_chk: assert property (@(posedge clk) disable iff (rst) sel <= SW'(Q - 1));

  // R1
  col_close_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && sel == SW'(Q - 1)) |=> (col_done && sel == '0));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> (!col_done && $stable(sel)));

  // R2
  stage_one_chk: assert property (@(posedge clk) disable iff (rst) col_done |=> y_vld);

  // R2
  stage_two_chk: assert property (@(posedge clk) disable iff (rst) y_vld |=> out_valid);

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst) out_valid |=> !out_valid);

  // R6
  reset_clear_chk: assert property (@(posedge clk) disable iff (!armed)
    $past(rst) |-> (sel == '0 && !col_done && !y_vld && !out_valid));

endmodule

bind polydft_expander polydft_expander_chk #(.Q(Q), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .accept(accept), .sel(sel),
  .col_done(col_done), .y_vld(y_vld), .out_valid(out_valid)
);

// File: tb/polydft_expander_bench.sv
module polydft_expander_bench;

  localparam int Q = 5, TAPS = 4, DW = 12, CW = 16, TW = 16, OW = 16, UNIT = 256;
  localparam int L = Q * TAPS;
  localparam real PI2 = 6.283185307179586;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic signed [DW-1:0] in_data = '0;
  logic                 out_valid;
  logic [Q*OW-1:0]      out_re, out_im;

  polydft_expander #(.Q(Q), .TAPS(TAPS), .DW(DW), .CW(CW), .TW(TW), .OW(OW), .COEF_UNIT(UNIT))
    u_polydft_expander (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_re(out_re), .out_im(out_im));

  always #4 clk = ~clk;

  int  vecs = 0, bad = 0, cnt = 0, due = -1;
  bit  finished = 0;
  int  xs [0:8191];
  real exp_re [Q];
  real exp_im [Q];
  logic [15:0] lfsr = 16'hACE1;

  function automatic real tap(input int i);
    int a;
    a = (i + 1 < L - i) ? i + 1 : L - i;
    return real'(a * UNIT) / 32768.0;
  endfunction

  // mix by e^(-j2*pi*k*s/Q), full-rate lowpass, keep sample t
  task automatic model(input int t);
    for (int k = 0; k < Q; k++) begin
      real re = 0.0, im = 0.0;
      for (int i = 0; i < L; i++) begin
        int s = t - i;
        if (s >= 0) begin
          real a = PI2 * real'(k) * real'(s) / real'(Q);
          re += tap(i) * real'(xs[s]) * $cos(a);
          im -= tap(i) * real'(xs[s]) * $sin(a);
        end
      end
      exp_re[k] = re;
      exp_im[k] = im;
    end
  endtask

  task automatic check_lanes(input string tag);
    for (int k = 0; k < Q; k++) begin
      real dr = real'($signed(out_re[k*OW +: OW])) - exp_re[k];
      real di = real'($signed(out_im[k*OW +: OW])) - exp_im[k];
      vecs++;
      if (dr > 2.0 || dr < -2.0 || di > 2.0 || di < -2.0) begin
        bad++;
        $display("FAIL %s lane %0d: actual (%0d,%0d) expected (%f,%f)", tag, k,
                 $signed(out_re[k*OW +: OW]), $signed(out_im[k*OW +: OW]), exp_re[k], exp_im[k]);
      end
    end
  endtask

  task automatic cyc(input bit v, input int d, input string tag);
    in_valid = v;
    in_data  = DW'(d);
    @(posedge clk);
    if (due > 0) due--;
    if (v) begin
      xs[cnt] = d;
      cnt++;
      if (cnt % Q == 0) begin
        model(cnt - 1);
        due = 2;
      end
    end
    @(negedge clk);
    vecs++;
    if (in_ready !== 1'b1) begin
      bad++;
      $display("FAIL R1 in_ready: actual %b expected 1", in_ready);
    end
    if (due == 0) begin
      vecs++;
      if (out_valid !== 1'b1) begin
        bad++;
        $display("FAIL R2 out_valid timing (%s): actual %b expected 1", tag, out_valid);
      end else check_lanes(tag);
      due = -1;
    end else if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R2/R5 stray out_valid (%s): actual %b expected 0", tag, out_valid);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    vecs++;
    if (out_valid !== 1'b0 || in_ready !== 1'b0) begin
      bad++;
      $display("FAIL R6 reset state: actual valid=%b ready=%b expected 0 0", out_valid, in_ready);
    end
    rst = 1'b0;
    cnt = 0;
    due = -1;
  endtask

  function automatic int rnd12();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return $signed(lfsr[11:0]);
  endfunction

  initial begin
    @(negedge clk);
    do_reset();
    // R6: output stays low right after reset
    cyc(1'b0, 0, "R6 idle after reset");

    // R4: impulses at every column offset, both extremes, then flush
    for (int sg = 0; sg < 2; sg++) begin
      for (int p = 0; p < Q; p++) begin
        for (int i = 0; i < Q + L; i++)
          cyc(1'b1, (i == p) ? (sg == 0 ? 2047 : -2048) : 0, "R4 impulse");
      end
    end

    // R3: full-scale DC, both signs
    for (int i = 0; i < 3 * L; i++) cyc(1'b1, 2047, "R3 dc max");
    for (int i = 0; i < 3 * L; i++) cyc(1'b1, -2048, "R3 dc min");

    // R7: tone at 2/Q of the sample rate lands on lane 2
    do_reset();
    for (int i = 0; i < 4 * L; i++)
      cyc(1'b1, $rtoi(1500.0 * $cos(PI2 * 2.0 * real'(i) / real'(Q))), "R7 tone bin2");

    // R3: alternating full-scale
    for (int i = 0; i < 2 * L; i++) cyc(1'b1, (i % 2) ? -2048 : 2047, "R3 alternating");

    // R6: reset in mid-column clears history and commutation
    do_reset();
    cyc(1'b1, 2047, "R6 pre");
    cyc(1'b1, -2048, "R6 pre");
    cyc(1'b1, 1234, "R6 pre");
    do_reset();
    for (int i = 0; i < 3 * Q; i++) cyc(1'b1, (i == 1) ? 1000 : 0, "R6 after mid reset");

    // R5: random data with idle gaps; R3: random data streamed back-to-back
    for (int i = 0; i < 1500; i++) begin
      int d = rnd12();
      cyc(lfsr[3] | lfsr[7], d, "R5 gapped random");
    end
    for (int i = 0; i < 1000; i++) cyc(1'b1, rnd12(), "R3 streamed random");
    for (int i = 0; i < 4; i++) cyc(1'b0, 0, "R5 drain");

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

endmodule